// File: doc/BRIEF.md
# Physical Register Free List

This block hands out unused physical register numbers to a register-renaming stage and takes them back when instructions retire. It keeps two separate first-in-first-out pools, one for integer registers and one for floating-point registers. Both classes share one index space: integer registers take the low indices and floating-point registers follow directly after them.

Each class has its own allocate request. The result, with a one-cycle valid strobe, appears in the cycle after the request. Registers come back in one of two ways. A shared release port looks at the index and sends it to the right pool. It discards the two hard-wired zero registers and any index beyond the register file. Per-class release ports push an index into their own pool without any filtering. Each pool reports whether it holds anything and how many entries it holds. It also pulses error flags when a request arrives on an empty pool and when a push would exceed the pool's capacity. After reset each pool holds, in ascending order, the physical registers that are not mapped to a logical register.

Top module: `phys_reg_free_list`

## Requirements
- R1: After reset the integer pool holds indices NUM_INT_LOGICAL up to NUM_INT_PHYS-1 in ascending order. The floating-point pool holds NUM_INT_PHYS+NUM_FP_LOGICAL up to NUM_INT_PHYS+NUM_FP_PHYS-1. All strobes and error flags are low.
- R2: Each pool is first-in-first-out: an allocation returns the oldest index present in that class's pool.
- R3: An accepted allocate request in cycle n gives `*_alloc_valid` high with the index in cycle n+1. The strobe is low in any cycle that follows no accepted request.
- R4: On the shared release port, an index below NUM_INT_PHYS goes to the integer pool. An index from NUM_INT_PHYS to NUM_INT_PHYS+NUM_FP_PHYS-1 goes to the floating-point pool.
- R5: The shared release port discards index ZERO_IDX (integer zero) and index ZERO_IDX+NUM_INT_PHYS (floating-point zero).
- R6: The shared release port ignores any index at or above NUM_INT_PHYS+NUM_FP_PHYS. Neither count changes.
- R7: The per-class release ports push whatever index they are given, zero registers included.
- R8: `*_nonempty` is high exactly when the pool count is non-zero. `*_free_cnt` equals the number of entries held.
- R9: An allocate request on an empty pool raises `*_underflow_err` for one cycle in the next cycle, gives no valid strobe, and leaves the pool unchanged.
- R10: An allocation and a release to the same non-empty pool in one cycle leave its count unchanged. If the pool was empty, the allocation is still flagged under R9 and the released index is kept.
- R11: A push that would take a pool past its physical register count is discarded. It raises `*_dfree_err` for one cycle in the next cycle.
- R12: When the shared port and a per-class port push into the same pool in one cycle, the shared-port index is queued first. If room remains for only one, the per-class push is the one discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_alloc_req | input | 1 | Request one integer register |
| int_alloc_valid | output | 1 | Integer allocation result valid |
| int_alloc_idx | output | IDX_W | Allocated integer physical index |
| fp_alloc_req | input | 1 | Request one floating-point register |
| fp_alloc_valid | output | 1 | Floating-point allocation result valid |
| fp_alloc_idx | output | IDX_W | Allocated floating-point physical index |
| rel_valid | input | 1 | Shared release strobe |
| rel_idx | input | IDX_W | Index returned on the shared port |
| int_rel_valid | input | 1 | Integer per-class release strobe |
| int_rel_idx | input | IDX_W | Index pushed to the integer pool |
| fp_rel_valid | input | 1 | Floating-point per-class release strobe |
| fp_rel_idx | input | IDX_W | Index pushed to the floating-point pool |
| int_nonempty | output | 1 | Integer pool holds at least one entry |
| int_free_cnt | output | clog2(NUM_INT_PHYS+1) | Integer pool entry count |
| fp_nonempty | output | 1 | Floating-point pool holds at least one entry |
| fp_free_cnt | output | clog2(NUM_FP_PHYS+1) | Floating-point pool entry count |
| int_underflow_err | output | 1 | Integer allocate on empty pool (previous cycle) |
| fp_underflow_err | output | 1 | Floating-point allocate on empty pool (previous cycle) |
| int_dfree_err | output | 1 | Integer push discarded for lack of room (previous cycle) |
| fp_dfree_err | output | 1 | Floating-point push discarded for lack of room (previous cycle) |

IDX_W is clog2(NUM_INT_PHYS+NUM_FP_PHYS+1), so that out-of-range indices can be represented.

## Verification
The assertions treat requests and release strobes as free inputs, with one condition: an index on a per-class port is taken as an opaque value. That value need not belong to that class, so no assertion checks pool contents against a class range. The directed stimulus still keeps per-class releases inside each class's range, so the bench's reference queues stay meaningful. It reaches the full and empty states only in a controlled way, which lets every overflow and underflow case be predicted exactly.

// File: rtl/preg_pkg.sv
`timescale 1ns/1ps
// Shared types for the physical register free list.
package preg_pkg;

    // Destination chosen for an index arriving on the shared release port.
    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_INT  = 2'd1,
        DST_FP   = 2'd2
    } rel_dest_e;

endpackage

// File: rtl/preg_release_router.sv
`timescale 1ns/1ps
// Classifies an index from the shared release port.
// Integer range is [0, INT_PHYS); floating range is [INT_PHYS, INT_PHYS+FP_PHYS).
// The two zero registers and indices past the end map to DST_NONE.
// Assumes IDX_W is wide enough to hold INT_PHYS+FP_PHYS.
module preg_release_router
    import preg_pkg::*;
#(
    parameter int INT_PHYS = 16,
    parameter int FP_PHYS  = 16,
    parameter int ZERO_IDX = 0,
    parameter int IDX_W    = 6
) (
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_idx,
    output rel_dest_e        dest
);
    localparam int TOTAL = INT_PHYS + FP_PHYS;
    localparam logic [IDX_W-1:0] INT_LIMIT = IDX_W'(INT_PHYS);
    localparam logic [IDX_W-1:0] ALL_LIMIT = IDX_W'(TOTAL);
    localparam logic [IDX_W-1:0] INT_ZERO  = IDX_W'(ZERO_IDX);
    localparam logic [IDX_W-1:0] FP_ZERO   = IDX_W'(ZERO_IDX + INT_PHYS);

    // Pick the destination pool by range, filtering zero registers.
    always_comb begin
        dest = DST_NONE;
        if (rel_valid) begin
            if (rel_idx < INT_LIMIT) begin
                if (rel_idx != INT_ZERO) dest = DST_INT;
            end else if (rel_idx < ALL_LIMIT) begin
                if (rel_idx != FP_ZERO) dest = DST_FP;
            end
        end
    end
endmodule

// File: rtl/preg_pool.sv
`timescale 1ns/1ps
// Circular first-in-first-out pool of free register indices.
// DEPTH slots; reset preloads INIT_CNT ascending values starting at INIT_BASE.
// Accepts one pop and two pushes (A before B) per cycle. A push beyond
// capacity is dropped and flagged. A pop on empty is flagged and has no effect.
// The pop result is registered: valid in the cycle after the request.
// Assumes INIT_CNT <= DEPTH.
module preg_pool #(
    parameter int DEPTH     = 16,
    parameter int INIT_CNT  = 8,
    parameter int INIT_BASE = 8,
    parameter int IDX_W     = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pop_req,
    input  logic                         push_a_v,
    input  logic [IDX_W-1:0]             push_a_idx,
    input  logic                         push_b_v,
    input  logic [IDX_W-1:0]             push_b_idx,
    output logic                         pop_valid,
    output logic [IDX_W-1:0]             pop_idx,
    output logic                         nonempty,
    output logic [$clog2(DEPTH+1)-1:0]   free_cnt,
    output logic                         underflow_err,
    output logic                         overflow_err
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] TAIL_RST = PTR_W'(INIT_CNT % DEPTH);

    logic [PTR_W-1:0]            head_q, tail_q, slot_b;
    logic [CNT_W-1:0]            cnt_q, cnt_mid, room, cnt_d;
    logic                        do_pop, acc_a, acc_b;
    logic [DEPTH-1:0][IDX_W-1:0] slot_w;

    // Advance a pointer by n slots around the ring.
    function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] p,
                                                  input logic [1:0] n);
        logic [PTR_W+1:0] s;
        s = {2'b00, p} + {{PTR_W{1'b0}}, n};
        if (s >= (PTR_W+2)'(DEPTH)) s = s - (PTR_W+2)'(DEPTH);
        return s[PTR_W-1:0];
    endfunction

    // Decide which of this cycle's pop and pushes take effect.
    always_comb begin
        do_pop  = pop_req && (cnt_q != '0);
        cnt_mid = cnt_q - CNT_W'(do_pop);
        room    = CNT_W'(DEPTH) - cnt_mid;
        acc_a   = push_a_v && (room != '0);
        acc_b   = push_b_v && (room > CNT_W'(acc_a));
        cnt_d   = cnt_mid + CNT_W'(acc_a) + CNT_W'(acc_b);
        slot_b  = acc_a ? ring_add(tail_q, 2'd1) : tail_q;
    end

    // One storage cell per slot; reset preloads the ascending free indices.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [IDX_W-1:0] RST_VAL =
            (g < INIT_CNT) ? IDX_W'(INIT_BASE + g) : '0;
        logic [IDX_W-1:0] cell_q;
        // Write the cell when either accepted push lands on it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   cell_q <= RST_VAL;
            else if (acc_a && tail_q == PTR_W'(g))        cell_q <= push_a_idx;
            else if (acc_b && slot_b == PTR_W'(g))        cell_q <= push_b_idx;
        end
        assign slot_w[g] = cell_q;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= TAIL_RST;
            cnt_q  <= CNT_W'(INIT_CNT);
        end else begin
            if (do_pop) head_q <= ring_add(head_q, 2'd1);
            tail_q <= ring_add(tail_q, {1'b0, acc_a} + {1'b0, acc_b});
            cnt_q  <= cnt_d;
        end
    end

    // Registered pop result and one-cycle error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid     <= 1'b0;
            pop_idx       <= '0;
            underflow_err <= 1'b0;
            overflow_err  <= 1'b0;
        end else begin
            pop_valid     <= do_pop;
            if (do_pop) pop_idx <= slot_w[head_q];
            underflow_err <= pop_req && (cnt_q == '0);
            overflow_err  <= (push_a_v && !acc_a) || (push_b_v && !acc_b);
        end
    end

    assign nonempty = (cnt_q != '0);
    assign free_cnt = cnt_q;

    // R11: occupancy never exceeds capacity.
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(DEPTH));
    // R3: a request on a non-empty pool yields a strobe next cycle.
    a_r3_pop_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && nonempty) |=> pop_valid);
    // R9: a request on an empty pool yields an error and no strobe.
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !nonempty) |=> (underflow_err && !pop_valid));
    // R9: with no push, the empty pool stays empty.
    a_r9_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !nonempty && !push_a_v && !push_b_v) |=> !nonempty);
    // R10: one pop plus one push on a non-empty pool keeps the count.
    a_r10_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && nonempty && (push_a_v ^ push_b_v)) |=> $stable(free_cnt));
    // R11: a full pool with a lone push and no pop flags a discard.
    a_r11_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_req && free_cnt == CNT_W'(DEPTH) && push_a_v) |=> overflow_err);
endmodule

// File: rtl/phys_reg_free_list.sv
`timescale 1ns/1ps
// Free list of physical registers for a rename stage: one integer pool and
// one floating-point pool over a shared index space (floating indices follow
// the integer ones). The shared release port is routed by range; the
// per-class release ports push unfiltered. Within a pool, the shared-port
// push is queued ahead of the per-class push.
// Assumes NUM_*_LOGICAL <= NUM_*_PHYS and ZERO_IDX < NUM_INT_PHYS.
module phys_reg_free_list
    import preg_pkg::*;
#(
    parameter int NUM_INT_LOGICAL = 8,
    parameter int NUM_INT_PHYS    = 16,
    parameter int NUM_FP_LOGICAL  = 8,
    parameter int NUM_FP_PHYS     = 16,
    parameter int ZERO_IDX        = 0
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              int_alloc_req,
    output logic                                              int_alloc_valid,
    output logic [$clog2(NUM_INT_PHYS+NUM_FP_PHYS+1)-1:0]     int_alloc_idx,
    input  logic                                              fp_alloc_req,
    output logic                                              fp_alloc_valid,
    output logic [$clog2(NUM_INT_PHYS+NUM_FP_PHYS+1)-1:0]     fp_alloc_idx,
    input  logic                                              rel_valid,
    input  logic [$clog2(NUM_INT_PHYS+NUM_FP_PHYS+1)-1:0]     rel_idx,
    input  logic                                              int_rel_valid,
    input  logic [$clog2(NUM_INT_PHYS+NUM_FP_PHYS+1)-1:0]     int_rel_idx,
    input  logic                                              fp_rel_valid,
    input  logic [$clog2(NUM_INT_PHYS+NUM_FP_PHYS+1)-1:0]     fp_rel_idx,
    output logic                                              int_nonempty,
    output logic [$clog2(NUM_INT_PHYS+1)-1:0]                 int_free_cnt,
    output logic                                              fp_nonempty,
    output logic [$clog2(NUM_FP_PHYS+1)-1:0]                  fp_free_cnt,
    output logic                                              int_underflow_err,
    output logic                                              fp_underflow_err,
    output logic                                              int_dfree_err,
    output logic                                              fp_dfree_err
);
    localparam int TOTAL = NUM_INT_PHYS + NUM_FP_PHYS;
    localparam int IDX_W = $clog2(TOTAL + 1);

    rel_dest_e route;

    preg_release_router #(
        .INT_PHYS (NUM_INT_PHYS),
        .FP_PHYS  (NUM_FP_PHYS),
        .ZERO_IDX (ZERO_IDX),
        .IDX_W    (IDX_W)
    ) u_router (
        .rel_valid (rel_valid),
        .rel_idx   (rel_idx),
        .dest      (route)
    );

    preg_pool #(
        .DEPTH     (NUM_INT_PHYS),
        .INIT_CNT  (NUM_INT_PHYS - NUM_INT_LOGICAL),
        .INIT_BASE (NUM_INT_LOGICAL),
        .IDX_W     (IDX_W)
    ) u_int_pool (
        .clk           (clk),
        .rst_n         (rst_n),
        .pop_req       (int_alloc_req),
        .push_a_v      (route == DST_INT),
        .push_a_idx    (rel_idx),
        .push_b_v      (int_rel_valid),
        .push_b_idx    (int_rel_idx),
        .pop_valid     (int_alloc_valid),
        .pop_idx       (int_alloc_idx),
        .nonempty      (int_nonempty),
        .free_cnt      (int_free_cnt),
        .underflow_err (int_underflow_err),
        .overflow_err  (int_dfree_err)
    );

    preg_pool #(
        .DEPTH     (NUM_FP_PHYS),
        .INIT_CNT  (NUM_FP_PHYS - NUM_FP_LOGICAL),
        .INIT_BASE (NUM_INT_PHYS + NUM_FP_LOGICAL),
        .IDX_W     (IDX_W)
    ) u_fp_pool (
        .clk           (clk),
        .rst_n         (rst_n),
        .pop_req       (fp_alloc_req),
        .push_a_v      (route == DST_FP),
        .push_a_idx    (rel_idx),
        .push_b_v      (fp_rel_valid),
        .push_b_idx    (fp_rel_idx),
        .pop_valid     (fp_alloc_valid),
        .pop_idx       (fp_alloc_idx),
        .nonempty      (fp_nonempty),
        .free_cnt      (fp_free_cnt),
        .underflow_err (fp_underflow_err),
        .overflow_err  (fp_dfree_err)
    );

    // R6: indices past the register file never reach a pool.
    a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && rel_idx >= IDX_W'(TOTAL)) |-> (route == DST_NONE));
    // R5: the integer zero register is never routed to the integer pool.
    a_r5_int_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && rel_idx == IDX_W'(ZERO_IDX)) |-> (route != DST_INT));
    // R5: the floating zero register is never routed to the floating pool.
    a_r5_fp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && rel_idx == IDX_W'(ZERO_IDX + NUM_INT_PHYS)) |-> (route != DST_FP));
    // R4: an integer-range index never lands in the floating pool.
    a_r4_int_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && rel_idx < IDX_W'(NUM_INT_PHYS)) |-> (route != DST_FP));
endmodule

// File: tb/tb_phys_reg_free_list.sv
`timescale 1ns/1ps
module tb_phys_reg_free_list;
    localparam int NIL = 8, NIP = 16, NFL = 8, NFP = 16, ZR = 0;
    localparam int TOT = NIP + NFP;
    localparam int IW  = $clog2(TOT + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic int_alloc_req = 0, fp_alloc_req = 0;
    logic rel_valid = 0, int_rel_valid = 0, fp_rel_valid = 0;
    logic [IW-1:0] rel_idx = '0, int_rel_idx = '0, fp_rel_idx = '0;
    logic int_alloc_valid, fp_alloc_valid, int_nonempty, fp_nonempty;
    logic [IW-1:0] int_alloc_idx, fp_alloc_idx;
    logic [$clog2(NIP+1)-1:0] int_free_cnt;
    logic [$clog2(NFP+1)-1:0] fp_free_cnt;
    logic int_underflow_err, fp_underflow_err, int_dfree_err, fp_dfree_err;

    int total = 0, bad = 0;
    int qi[$];
    int qf[$];

    always #2.5 clk = ~clk;

    phys_reg_free_list #(.NUM_INT_LOGICAL(NIL), .NUM_INT_PHYS(NIP),
        .NUM_FP_LOGICAL(NFL), .NUM_FP_PHYS(NFP), .ZERO_IDX(ZR)) dut (.*);

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Model of one pool for one cycle; returns expected strobe/index/flags.
    task automatic model_pool(ref int q[$], input int depth, input bit req,
                              input bit pa, input int ia, input bit pb, input int ib,
                              output bit v, output int idx, output bit uf, output bit df);
        int room;
        v = 0; idx = 0; uf = 0; df = 0;
        if (req) begin
            if (q.size() == 0) uf = 1;
            else begin v = 1; idx = q.pop_front(); end
        end
        room = depth - q.size();
        if (pa) begin if (room > 0) begin q.push_back(ia); room--; end else df = 1; end
        if (pb) begin if (room > 0) q.push_back(ib); else df = 1; end
    endtask

    // Drive one cycle, advance past the edge, and compare all outputs.
    task automatic tick(string tag, bit ia, bit fa, bit rv, int ri,
                        bit irv, int iri, bit frv, int fri);
        bit toi, tof, v, uf, df;
        int idx;
        toi = rv && ri < NIP && ri != ZR;
        tof = rv && ri >= NIP && ri < TOT && ri != ZR + NIP;
        int_alloc_req = ia; fp_alloc_req = fa;
        rel_valid = rv; rel_idx = IW'(ri);
        int_rel_valid = irv; int_rel_idx = IW'(iri);
        fp_rel_valid = frv; fp_rel_idx = IW'(fri);
        @(negedge clk);
        model_pool(qi, NIP, ia, toi, ri, irv, iri, v, idx, uf, df);
        chk(tag, "int_alloc_valid", int'(int_alloc_valid), int'(v));
        if (v) chk(tag, "int_alloc_idx", int'(int_alloc_idx), idx);
        chk(tag, "int_underflow_err", int'(int_underflow_err), int'(uf));
        chk(tag, "int_dfree_err", int'(int_dfree_err), int'(df));
        chk(tag, "int_free_cnt", int'(int_free_cnt), qi.size());
        chk(tag, "int_nonempty", int'(int_nonempty), int'(qi.size() != 0));
        model_pool(qf, NFP, fa, tof, ri, frv, fri, v, idx, uf, df);
        chk(tag, "fp_alloc_valid", int'(fp_alloc_valid), int'(v));
        if (v) chk(tag, "fp_alloc_idx", int'(fp_alloc_idx), idx);
        chk(tag, "fp_underflow_err", int'(fp_underflow_err), int'(uf));
        chk(tag, "fp_dfree_err", int'(fp_dfree_err), int'(df));
        chk(tag, "fp_free_cnt", int'(fp_free_cnt), qf.size());
        chk(tag, "fp_nonempty", int'(fp_nonempty), int'(qf.size() != 0));
        int_alloc_req = 0; fp_alloc_req = 0;
        rel_valid = 0; int_rel_valid = 0; fp_rel_valid = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        qi.delete(); qf.delete();
        for (int i = NIL; i < NIP; i++) qi.push_back(i);
        for (int i = NIP + NFL; i < TOT; i++) qf.push_back(i);
        chk("R1", "int_free_cnt", int'(int_free_cnt), NIP - NIL);
        chk("R1", "fp_free_cnt", int'(fp_free_cnt), NFP - NFL);
        chk("R8", "int_nonempty", int'(int_nonempty), 1);
        chk("R1", "strobes+errors", int'({int_alloc_valid, fp_alloc_valid,
            int_underflow_err, fp_underflow_err, int_dfree_err, fp_dfree_err}), 0);
    endtask

    task automatic t_drain();
        // R1/R2: initial contents come out ascending; R3: strobe then idle.
        for (int i = 0; i < NIP - NIL; i++) tick("R1", 1, 0, 0, 0, 0, 0, 0, 0);
        tick("R3", 0, 0, 0, 0, 0, 0, 0, 0);
        tick("R2", 0, 1, 0, 0, 0, 0, 0, 0);
        tick("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_empty_alloc();
        tick("R9", 1, 0, 0, 0, 0, 0, 0, 0);
        tick("R9", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_shared_release();
        tick("R4", 0, 0, 1, 5, 0, 0, 0, 0);
        tick("R4", 0, 0, 1, 20, 0, 0, 0, 0);
        tick("R5", 0, 0, 1, ZR, 0, 0, 0, 0);
        tick("R5", 0, 0, 1, ZR + NIP, 0, 0, 0, 0);
        tick("R6", 0, 0, 1, TOT, 0, 0, 0, 0);
        tick("R6", 0, 0, 1, 40, 0, 0, 0, 0);
        tick("R6", 0, 0, 1, (1 << IW) - 1, 0, 0, 0, 0);
    endtask

    task automatic t_direct_release();
        tick("R7", 0, 0, 0, 0, 1, ZR, 1, ZR + NIP);
        tick("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        tick("R7", 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_same_cycle();
        tick("R10", 1, 0, 1, 9, 0, 0, 0, 0);
        tick("R10", 1, 0, 0, 0, 1, 11, 0, 0);
    endtask

    task automatic t_double_free();
        int fill;
        fill = 17;
        while (qf.size() < NFP) begin
            tick("R11", 0, 0, 0, 0, 0, 0, 1, fill);
            fill++;
        end
        tick("R11", 0, 0, 0, 0, 0, 0, 1, 25);
        tick("R10", 0, 1, 0, 0, 0, 0, 1, 26);
    endtask

    task automatic t_dual_push();
        tick("R12", 0, 0, 1, 3, 1, 7, 0, 0);
        for (int i = 0; i < 3; i++) tick("R12", 1, 0, 0, 0, 0, 0, 0, 0);
        tick("R12", 0, 1, 1, 27, 0, 0, 1, 28);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_drain();
        t_empty_alloc();
        t_shared_release();
        t_direct_release();
        t_same_cycle();
        t_double_free();
        t_dual_push();
        t_reset();
        tick("R1", 0, 1, 0, 0, 0, 0, 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule